// File: doc/BRIEF.md
# Multi-Channel Shared-Period PWM Generator

This block produces several pulse-width-modulated outputs that all run on one common time base. An 8-bit prescaler divides the input clock into local ticks, and a free-running 8-bit counter steps once per tick from 0 to 255 and then wraps. One period therefore lasts (prescale+1)×256 input clock cycles. Each channel compares its own duty value against the shared counter and drives its output high while the counter has not passed that value. The pulse is always the duty value plus one local tick wide, so a duty of 0 still gives a one-tick pulse and a duty of 255 keeps the output high for the whole period.

Software controls the block through a 32-bit word register interface with a byte address and combinational read data. The interface holds one duty register per channel, a control word, an interrupt-enable word, a write-one-to-clear wrap status and a read-only view of the counter. The control word carries the prescaler split into two separated nibbles and one run bit shared by the counter and every output. Duty and prescaler writes take effect only at the next wrap, so a period is never cut or stretched part way through. The one exception is the cycle the block is switched on, which starts from the values already written.

Top module: `pwm_shared_period`

## Requirements
- R1: After reset every register reads 0, every channel output is low and `irq` is low.
- R2: The control word sits at byte offset 0x50. Prescaler bits 3:0 are stored in control bits 3:0, prescaler bits 7:4 in control bits 14:11, and the run bit in control bit 9. The other bits read back as 0.
- R3: While running, the counter advances by one every prescale+1 input cycles, runs 0 to 255 and wraps to 0. A period lasts (prescale+1)×256 input cycles.
- R4: Channel n's duty register is at byte offset 4×n and holds its value in bits 7:0. While running, output n is high exactly while counter ≤ active duty, which gives duty+1 high ticks per period. A duty of 255 never goes low.
- R5: While running, a new duty or prescaler value takes effect only at the first counter wrap after the write. In the first cycle after the run bit is set, the values currently held in the registers are used.
- R6: While the run bit is 0, the counter and the prescale divider are held at 0 and every output is low.
- R7: Status bit 0 at byte offset 0x58 is set on each counter wrap and is cleared by writing 1 to bit 0. If a wrap and a clearing write fall in the same cycle, the bit ends up set.
- R8: `irq` is high exactly when the wrap status bit and bit 0 of the interrupt-enable word at byte offset 0x54 are both 1.
- R9: The counter reads back at byte offset 0x60 in bits 7:0. Writes to that offset have no effect.
- R10: Reads of unmapped offsets, including duty slots at or above the channel count, return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | Channel outputs |
| irq | output | 1 | Wrap interrupt |

## Verification
Two pairs of events can fall in the same cycle. The first is a counter wrap together with a software write that clears the status bit. The bench watches its own model of the time base, waits for the cycle in which the counter sits at 255 on its final divider step, and issues the clearing write in exactly that cycle; it then expects the status bit to read 1, and a later clearing write with no wrap to read 0. The second is a duty or prescaler write that lands in the same cycle as a wrap, which must not be latched until the following wrap. Random traffic provokes this many times with small prescalers, and every output, the interrupt and every read are compared each cycle against the bench model.

// File: rtl/pwm_sp_pkg.sv
package pwm_sp_pkg;
  localparam int PSC_W      = 8;
  // word indices (byte offset / 4)
  localparam int WIDX_CTRL  = 20;
  localparam int WIDX_IEN   = 21;
  localparam int WIDX_STAT  = 22;
  localparam int WIDX_CNT   = 24;
  localparam int RUN_BIT    = 9;

  function automatic logic [PSC_W-1:0] ctrl_to_psc(input logic [31:0] w);
    return {w[14:11], w[3:0]};
  endfunction

  function automatic logic [31:0] psc_to_ctrl(input logic [PSC_W-1:0] p, input logic run);
    logic [31:0] w;
    w = '0;
    w[3:0]    = p[3:0];
    w[14:11]  = p[7:4];
    w[RUN_BIT] = run;
    return w;
  endfunction

  // channel drives high while count has not passed its duty
  function automatic logic duty_active(input logic [7:0] cnt, input logic [7:0] duty);
    return cnt <= duty;
  endfunction
endpackage

// File: rtl/pwm_sp_regs.sv
module pwm_sp_regs
  import pwm_sp_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 8,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 wrap_evt,
  input  logic [CNT_W-1:0]     cnt_val,
  output logic [NCH*CNT_W-1:0] duty_flat,
  output logic [PSC_W-1:0]     psc_reg,
  output logic                 run_en,
  output logic                 irq_en,
  output logic                 irq_stat
);
  localparam int WI = AW - 2;

  logic [WI-1:0] widx;
  logic          wr;
  logic          clr_req;

  assign widx    = bus_addr[AW-1:2];
  assign wr      = bus_sel & bus_we;
  assign clr_req = wr && (widx == WI'(WIDX_STAT)) && bus_wdata[0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_duty
    logic [CNT_W-1:0] duty_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                        duty_q <= '0;
      else if (wr && widx == WI'(ch))    duty_q <= bus_wdata[CNT_W-1:0];
    end
    assign duty_flat[ch*CNT_W +: CNT_W] = duty_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc_reg  <= '0;
      run_en   <= 1'b0;
      irq_en   <= 1'b0;
      irq_stat <= 1'b0;
    end else begin
      if (wr && widx == WI'(WIDX_CTRL)) begin
        psc_reg <= ctrl_to_psc(bus_wdata);
        run_en  <= bus_wdata[RUN_BIT];
      end
      if (wr && widx == WI'(WIDX_IEN)) irq_en <= bus_wdata[0];
      // a wrap in the same cycle outranks the clear
      if (wrap_evt)     irq_stat <= 1'b1;
      else if (clr_req) irq_stat <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int ch = 0; ch < NCH; ch++)
      if (widx == WI'(ch)) bus_rdata[CNT_W-1:0] = duty_flat[ch*CNT_W +: CNT_W];
    if (widx == WI'(WIDX_CTRL)) bus_rdata = psc_to_ctrl(psc_reg, run_en);
    if (widx == WI'(WIDX_IEN))  bus_rdata[0] = irq_en;
    if (widx == WI'(WIDX_STAT)) bus_rdata[0] = irq_stat;
    if (widx == WI'(WIDX_CNT))  bus_rdata[CNT_W-1:0] = cnt_val;
  end
endmodule

// File: rtl/pwm_sp_timebase.sv
module pwm_sp_timebase
  import pwm_sp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PSC_W-1:0] psc_reg,
  output logic [CNT_W-1:0] cnt_val,
  output logic [PSC_W-1:0] act_psc,
  output logic             tick,
  output logic             wrap_evt,
  output logic             load,
  output logic             fresh
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [PSC_W-1:0] div_q;
  logic [PSC_W-1:0] eff_psc;
  logic             run_q;

  assign fresh    = ~run_q;
  assign eff_psc  = fresh ? psc_reg : act_psc;
  assign tick     = run_en && (div_q == eff_psc);
  assign wrap_evt = tick && (cnt_val == CNT_TOP);
  assign load     = fresh || wrap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_val <= '0;
      act_psc <= '0;
      run_q   <= 1'b0;
    end else begin
      run_q <= run_en;
      if (load) act_psc <= psc_reg;
      if (!run_en) begin
        div_q   <= '0;
        cnt_val <= '0;
      end else if (tick) begin
        div_q   <= '0;
        cnt_val <= cnt_val + 1'b1;
      end else begin
        div_q   <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_sp_channel.sv
module pwm_sp_channel
  import pwm_sp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             load,
  input  logic             fresh,
  input  logic [CNT_W-1:0] duty_reg,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             pwm_o
);
  logic [CNT_W-1:0] act_duty;
  logic [CNT_W-1:0] eff_duty;

  always_ff @(posedge clk) begin
    if (!rst_n)    act_duty <= '0;
    else if (load) act_duty <= duty_reg;
  end

  assign eff_duty = fresh ? duty_reg : act_duty;
  assign pwm_o    = run_en && duty_active(8'(cnt_val), 8'(eff_duty));
endmodule

// File: rtl/pwm_shared_period.sv
module pwm_shared_period
  import pwm_sp_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int AW    = 8,
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);
  logic [NCH*CNT_W-1:0] duty_flat;
  logic [PSC_W-1:0]     psc_reg;
  logic [PSC_W-1:0]     act_psc;
  logic [CNT_W-1:0]     cnt_val;
  logic                 run_en, irq_en, irq_stat;
  logic                 tick, wrap_evt, load, fresh;

  pwm_sp_regs #(.NCH(NCH), .AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wrap_evt(wrap_evt), .cnt_val(cnt_val), .duty_flat(duty_flat),
    .psc_reg(psc_reg), .run_en(run_en), .irq_en(irq_en), .irq_stat(irq_stat)
  );

  pwm_sp_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .psc_reg(psc_reg),
    .cnt_val(cnt_val), .act_psc(act_psc), .tick(tick),
    .wrap_evt(wrap_evt), .load(load), .fresh(fresh)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_sp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .load(load), .fresh(fresh),
      .duty_reg(duty_flat[ch*CNT_W +: CNT_W]), .cnt_val(cnt_val),
      .pwm_o(pwm_out[ch])
    );
  end

  assign irq = irq_stat & irq_en;
endmodule

// File: rtl/pwm_shared_period_chk.sv
module pwm_shared_period_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             tick,
  input logic             wrap_evt,
  input logic             fresh,
  input logic [CNT_W-1:0] cnt_val,
  input logic [7:0]       act_psc,
  input logic             irq_stat,
  input logic             irq_en,
  input logic             irq,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [NCH-1:0]   pwm_out
);
  AST_OFF_OUT_LOW:   assert property (@(posedge clk) disable iff (!rst_n) !run_en |-> pwm_out == '0); // R6
  AST_OFF_CNT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> cnt_val == '0); // R6
  AST_HOLD_NO_TICK:  assert property (@(posedge clk) disable iff (!rst_n) (run_en && !tick) |=> $stable(cnt_val)); // R3
  AST_WRAP_TO_ZERO:  assert property (@(posedge clk) disable iff (!rst_n) wrap_evt |=> cnt_val == '0); // R3
  AST_ZERO_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (run_en && cnt_val == '0) |-> &pwm_out); // R4
  AST_PSC_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (run_en && !fresh && !wrap_evt) |=> $stable(act_psc)); // R5
  AST_WRAP_SETS_ST:  assert property (@(posedge clk) disable iff (!rst_n) wrap_evt |=> irq_stat); // R7
  AST_IRQ_RAISE:     assert property (@(posedge clk) disable iff (!rst_n) (wrap_evt && irq_en && !(bus_sel && bus_we)) |=> irq); // R8
endmodule

bind pwm_shared_period pwm_shared_period_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .wrap_evt(wrap_evt),
  .fresh(fresh), .cnt_val(cnt_val), .act_psc(act_psc), .irq_stat(irq_stat),
  .irq_en(irq_en), .irq(irq), .bus_sel(bus_sel), .bus_we(bus_we), .pwm_out(pwm_out)
);

// File: tb/pwm_shared_period_tb_top.sv
module pwm_shared_period_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic        irq;

  int vecs = 0, errs = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shared_period dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  // ---- bench model, written from the requirements ----
  logic [7:0] m_duty [NCH];
  logic [7:0] m_aduty[NCH];
  logic [7:0] m_psc, m_apsc, m_div, m_cnt;
  logic       m_en, m_ie, m_stat, m_runq;

  function automatic logic [31:0] bench_ctrl(input logic [7:0] p, input logic en);
    return {17'b0, p[7:4], 1'b0, en, 5'b0, p[3:0]};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int w = int'(a[7:2]);
    if (w < NCH) return {24'b0, m_duty[w]};
    case (w)
      20: return bench_ctrl(m_psc, m_en);
      21: return {31'b0, m_ie};
      22: return {31'b0, m_stat};
      24: return {24'b0, m_cnt};
      default: return 32'b0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] model_out();
    logic [NCH-1:0] o;
    for (int c = 0; c < NCH; c++)
      o[c] = m_en && (m_cnt <= (m_runq ? m_aduty[c] : m_duty[c]));
    return o;
  endfunction

  function automatic logic model_tick();
    return m_en && (m_div == (m_runq ? m_apsc : m_psc));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin m_duty[c] = '0; m_aduty[c] = '0; end
      m_psc = '0; m_apsc = '0; m_div = '0; m_cnt = '0;
      m_en = 0; m_ie = 0; m_stat = 0; m_runq = 0;
    end else begin
      logic tk, wp, ld, wr;
      int w;
      tk = model_tick();
      wp = tk && (m_cnt == 8'd255);
      ld = !m_runq || wp;
      wr = bus_sel && bus_we;
      w  = int'(bus_addr[7:2]);
      if (ld) begin
        m_apsc = m_psc;
        for (int c = 0; c < NCH; c++) m_aduty[c] = m_duty[c];
      end
      if (!m_en) begin m_div = 0; m_cnt = 0; end
      else if (tk) begin m_div = 0; m_cnt = m_cnt + 8'd1; end
      else m_div = m_div + 8'd1;
      m_runq = m_en;
      if (wp) m_stat = 1;
      else if (wr && w == 22 && bus_wdata[0]) m_stat = 0;
      if (wr) begin
        if (w < NCH) m_duty[w] = bus_wdata[7:0];
        else if (w == 20) begin m_psc = {bus_wdata[14:11], bus_wdata[3:0]}; m_en = bus_wdata[9]; end
        else if (w == 21) m_ie = bus_wdata[0];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      check(pwm_out === model_out(), "R4 outputs", 32'(pwm_out), 32'(model_out()));
      check(irq === (m_stat & m_ie), "R8 irq", 32'(irq), 32'(m_stat & m_ie));
      if (bus_sel && !bus_we)
        check(bus_rdata === model_read(bus_addr), "R2/R9/R10 read", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic drive(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d); drive(1, 1, a, d); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) drive(0, 0, 8'h00, 32'h0); endtask
  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    drive(1, 0, a, 32'h0);
    @(negedge clk);
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int hi[NCH];
    int zeros;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1; live = 1;

    // R1 reset state
    @(negedge clk);
    check(pwm_out === '0, "R1 outputs low", 32'(pwm_out), 0);
    check(irq === 1'b0, "R1 irq low", 32'(irq), 0);
    rd_chk(8'h50, 0, "R1 ctrl");
    rd_chk(8'h58, 0, "R1 status");
    rd_chk(8'h60, 0, "R1 counter");
    rd_chk(8'h04, 0, "R1 duty1");

    // R2 field placement
    wr(8'h50, bench_ctrl(8'h5A, 0));
    rd_chk(8'h50, 32'h0000_280A, "R2 split prescaler");
    wr(8'h50, 32'hFFFF_FFFF);
    rd_chk(8'h50, 32'h0000_7A0F, "R2 reserved bits zero");
    wr(8'h50, 32'h0);

    // R10 unmapped / R9 read-only counter
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0000_00FF);
    rd_chk(8'h5C, 0, "R10 unmapped 0x5C");
    rd_chk(8'h44, 0, "R10 duty slot beyond channels");
    wr(8'h60, 32'h55);
    rd_chk(8'h60, 0, "R9 counter write ignored");

    // R3 with a high-nibble prescaler: 0x10 -> 17 cycles per tick
    wr(8'h50, bench_ctrl(8'h10, 1));
    drive(1, 0, 8'h60, 0);
    zeros = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bus_rdata == 0) zeros++;
    end
    check(zeros == 17, "R3 tick spacing prescale 0x10", zeros, 17);
    wr(8'h50, 32'h0);
    idle(2);
    check(pwm_out === '0, "R6 outputs low when stopped", 32'(pwm_out), 0);
    rd_chk(8'h60, 0, "R6 counter held at zero");

    // R4 pulse widths over one whole period, prescale 1
    wr(8'h00, 32'd0); wr(8'h04, 32'd255); wr(8'h08, 32'd100); wr(8'h0C, 32'd7);
    wr(8'h54, 32'h1);
    wr(8'h50, bench_ctrl(8'h01, 1));
    idle(1);
    for (int c = 0; c < NCH; c++) hi[c] = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) if (pwm_out[c]) hi[c]++;
    end
    check(hi[0] == 2,   "R4 duty 0 one tick",  hi[0], 2);
    check(hi[1] == 512, "R4 duty 255 never low", hi[1], 512);
    check(hi[2] == 202, "R4 duty 100",         hi[2], 202);
    check(hi[3] == 16,  "R4 duty 7",           hi[3], 16);
    @(negedge clk);
    check(irq === 1'b1, "R8 irq after wrap", 32'(irq), 1);

    // R5 duty change waits for the wrap
    wr(8'h00, 32'd200);
    idle(20);
    @(negedge clk);
    check(pwm_out[0] === 1'b0, "R5 old duty held mid-period", 32'(pwm_out[0]), 0);

    // R7 collision: clear lands on the wrap cycle
    wr(8'h50, bench_ctrl(8'h00, 1));
    drive(0, 0, 0, 0);
    while (!(model_tick() && m_cnt == 8'd255)) drive(0, 0, 0, 0);
    bus_sel = 1; bus_we = 1; bus_addr = 8'h58; bus_wdata = 32'h1;
    rd_chk(8'h58, 1, "R7 wrap outranks clear");
    wr(8'h54, 32'h0);
    idle(1);
    @(negedge clk);
    check(irq === 1'b0, "R8 irq gated off", 32'(irq), 0);
    wr(8'h58, 32'h1);
    rd_chk(8'h58, 0, "R7 clear without wrap");

    // random traffic with small prescalers
    for (int i = 0; i < 30000; i++) begin
      logic [7:0] addrs[10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h50, 8'h54, 8'h58, 8'h60, 8'h5C, 8'h44};
      logic [7:0] a;
      logic [31:0] d;
      a = addrs[$urandom_range(0, 9)];
      d = $urandom;
      if (a == 8'h50) begin
        d = d & 32'hFFFF_85F3;
        if ($urandom_range(0, 9) != 0) d = d | 32'h200;
      end
      case ($urandom_range(0, 3))
        0: drive(1, 1, a, d);
        1: drive(1, 0, a, 0);
        default: drive(0, 0, 0, 0);
      endcase
    end
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule